// File: doc/BRIEF.md
# Periodic Wakeup Down-Counter

This block produces a periodic wakeup event from a slow timekeeping tick. A down-counter is loaded from a 16-bit reload value and steps on one of several step sources. Four of them are the raw tick divided by 16, 8, 4 or 2. The other two use a once-per-second tick: one as it is, and one with 2^16 added to every count period. When the counter steps while it holds zero, it reloads itself and sets a sticky wakeup flag. The interrupt output is that flag gated by an interrupt enable.

Both ticks arrive as single-cycle strobes in the system clock domain. A write-allowed status models the settling time after the timer is switched off. The reload value and the step-source select are taken in only while that status is high. Values presented at other times are ignored, and the last accepted ones stay in use. Software clears the enable, waits for the status, changes the settings and then enables the timer again. Enabling the timer restarts the divider and loads the counter.

Top module: `wakeup_timer`

## Requirements
- R1: After reset `wake_flag` and `wake_irq` are 0 and `wr_ok` is 1.
- R2: With `clk_sel` 000, 001, 010 or 011, the counter steps on every 16th, 8th, 4th or 2nd `rtc_tick` after enabling. The first flag sets on tick number (reload+1) times that divisor.
- R3: With `clk_sel` 100 or 101, the counter steps on `sec_tick`, and the first flag sets on `sec_tick` number reload+1.
- R4: With `clk_sel` 110 or 111, the counter steps on `sec_tick`, and each period lasts reload+1+65536 steps.
- R5: The counter reloads itself when it wraps, so after the first flag the next flag follows (reload+1) steps later. The flag stays set until it is cleared.
- R6: A one-cycle `flag_clr` clears the flag. If a wrap happens in the same cycle, the flag stays set.
- R7: `wake_irq` is high exactly when `wake_flag` and `irq_en` are both high.
- R8: `wr_ok` is 0 from the cycle after `tmr_en` is seen high. After `tmr_en` is cleared, `wr_ok` rises on the second `rtc_tick`.
- R9: Values on `reload` and `clk_sel` are ignored while `wr_ok` is 0. Re-enabling before `wr_ok` rises uses the last values that were accepted.
- R10: While `tmr_en` is 0 the counter does not step and the flag does not set. Enabling again restarts the count from the full reload value.
- R11: In the divided modes `sec_tick` has no effect. In the once-per-second modes `rtc_tick` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle strobe per raw tick |
| sec_tick | input | 1 | One-cycle strobe per second |
| tmr_en | input | 1 | Timer enable |
| irq_en | input | 1 | Interrupt enable |
| clk_sel | input | 3 | Step-source select (encoding in R2 to R4) |
| reload | input | 16 | Reload value |
| flag_clr | input | 1 | One-cycle flag clear |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | Wakeup interrupt |
| wr_ok | output | 1 | Settings may be changed |

## Verification
A step strobe that lands on a wrap changes `wake_flag` at the same clock edge. So the bench holds a tick strobe high for exactly the number of edges required, then reads the flag at the following falling edge. It does this once for the count one short of the expected wrap and once for the wrapping count. `wake_irq` follows its inputs with no register on the way. `wr_ok` falls one edge after the enable is seen, and rises at the edge of the second raw tick after disable. Each of these is sampled at the first falling edge after the edge where it is due.

// File: rtl/wakeup_timer.sv
module wakeup_timer #(
  parameter int RW     = 16,
  parameter int DIV_W  = 4,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtc_tick,
  input  logic          sec_tick,
  input  logic          tmr_en,
  input  logic          irq_en,
  input  logic [2:0]    clk_sel,
  input  logic [RW-1:0] reload,
  input  logic          flag_clr,
  output logic          wake_flag,
  output logic          wake_irq,
  output logic          wr_ok
);
  localparam int CW = RW + 1;
  localparam int SW = $clog2(SETTLE + 1);

  logic          running;
  logic [DIV_W-1:0] pre;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rel_q;
  logic [2:0]    sel_q;
  logic [SW-1:0] settle;

  logic [2:0]       eff_sel;
  logic [RW-1:0]    eff_rel;
  logic [DIV_W-1:0] mask;
  logic [CW-1:0]    start_val;
  logic             start, div_hit, step, wrap;

  assign eff_sel   = wr_ok ? clk_sel : sel_q;
  assign eff_rel   = wr_ok ? reload  : rel_q;
  assign mask      = {DIV_W{1'b1}} >> eff_sel[1:0];
  assign start_val = {eff_sel[2] & eff_sel[1], eff_rel};
  assign start     = tmr_en && !running;
  assign div_hit   = rtc_tick && ((pre & mask) == mask);
  assign step      = running && (eff_sel[2] ? sec_tick : div_hit);
  assign wrap      = step && (cnt == '0);
  assign wr_ok     = !running && (settle == SW'(SETTLE));
  assign wake_irq  = wake_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre     <= '0;
      cnt     <= '0;
      rel_q   <= '0;
      sel_q   <= '0;
      settle  <= SW'(SETTLE);
    end else begin
      running <= tmr_en;
      if (!running)     pre <= '0;
      else if (rtc_tick) pre <= pre + 1'b1;
      if (start)        cnt <= start_val;
      else if (wrap)    cnt <= start_val;
      else if (step)    cnt <= cnt - 1'b1;
      if (wr_ok) begin
        rel_q <= reload;
        sel_q <= clk_sel;
      end
      if (running)                                     settle <= '0;
      else if (rtc_tick && settle != SW'(SETTLE))      settle <= settle + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_flag <= 1'b0;
    else if (wrap)     wake_flag <= 1'b1;
    else if (flag_clr) wake_flag <= 1'b0;
  end

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_flag) |-> $past(flag_clr));
  assert_flag_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(rtc_tick || sec_tick));
  assert_flag_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(running));
  assert_busy_when_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tmr_en) |-> !wr_ok);
  assert_settings_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ok) |-> ($stable(rel_q) && $stable(sel_q)));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !wake_irq);
endmodule

// File: tb/test_wakeup_timer.sv
module test_wakeup_timer;
  logic clk = 0, rst_n = 0;
  logic rtc_tick = 0, sec_tick = 0, tmr_en = 0, irq_en = 0, flag_clr = 0;
  logic [2:0]  clk_sel = 0;
  logic [15:0] reload = 0;
  logic wake_flag, wake_irq, wr_ok;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wakeup_timer i_wakeup_timer (.clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick),
    .sec_tick(sec_tick), .tmr_en(tmr_en), .irq_en(irq_en), .clk_sel(clk_sel),
    .reload(reload), .flag_clr(flag_clr), .wake_flag(wake_flag),
    .wake_irq(wake_irq), .wr_ok(wr_ok));

  // {first-flag tick count, reload, select}
  localparam logic [38:0] VEC [0:6] = '{
    {20'd32, 16'd1, 3'b000}, {20'd24, 16'd2, 3'b001}, {20'd4, 16'd0, 3'b010},
    {20'd4,  16'd1, 3'b011}, {20'd12, 16'd5, 3'b011}, {20'd3, 16'd2, 3'b100},
    {20'd1,  16'd0, 3'b101}};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic pulse_rtc(input int n);
    if (n > 0) begin
      @(negedge clk) rtc_tick = 1;
      repeat (n) @(negedge clk);
      rtc_tick = 0;
    end
  endtask

  task automatic pulse_sec(input int n);
    if (n > 0) begin
      @(negedge clk) sec_tick = 1;
      repeat (n) @(negedge clk);
      sec_tick = 0;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1;
    @(negedge clk) flag_clr = 0;
  endtask

  task automatic arm(input logic [2:0] s, input logic [15:0] r);
    @(negedge clk) tmr_en = 0;
    pulse_rtc(2);
    clk_sel = s; reload = r;
    clear_flag();
    tmr_en = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag", wake_flag, 0);
    chk("R1 irq", wake_irq, 0);
    chk("R1 wr_ok", wr_ok, 1);

    for (int i = 0; i < 7; i++) begin
      arm(VEC[i][2:0], VEC[i][18:3]);
      if (VEC[i][2]) pulse_sec(int'(VEC[i][38:19]) - 1);
      else           pulse_rtc(int'(VEC[i][38:19]) - 1);
      chk(VEC[i][2] ? "R3 early" : "R2 early", wake_flag, 0);
      if (VEC[i][2]) pulse_sec(1); else pulse_rtc(1);
      chk(VEC[i][2] ? "R3 due" : "R2 due", wake_flag, 1);
    end

    // R4: long once-per-second mode
    arm(3'b110, 16'd0);
    pulse_sec(65536);
    chk("R4 early", wake_flag, 0);
    pulse_sec(1);
    chk("R4 due", wake_flag, 1);

    // R5 auto-reload and stickiness
    arm(3'b011, 16'd1);
    pulse_rtc(4);
    pulse_rtc(3);
    chk("R5 sticky", wake_flag, 1);
    clear_flag();
    chk("R6 cleared", wake_flag, 0);
    pulse_rtc(1);
    chk("R5 second period", wake_flag, 1);
    // R6 set wins over clear: next wrap after 4 more ticks
    clear_flag();
    pulse_rtc(3);
    @(negedge clk) begin rtc_tick = 1; flag_clr = 1; end
    @(negedge clk) begin rtc_tick = 0; flag_clr = 0; end
    chk("R6 set wins", wake_flag, 1);

    // R7 interrupt gating
    irq_en = 0; #1;
    chk("R7 masked", wake_irq, 0);
    irq_en = 1; #1;
    chk("R7 raised", wake_irq, 1);
    clear_flag();
    chk("R7 after clear", wake_irq, 0);
    irq_en = 0;

    // R11: other tick source ignored
    arm(3'b010, 16'd0);
    pulse_sec(20);
    chk("R11 sec ignored", wake_flag, 0);
    arm(3'b100, 16'd0);
    pulse_rtc(40);
    chk("R11 rtc ignored", wake_flag, 0);

    // R8 write-allowed handshake
    arm(3'b011, 16'd1);
    chk("R8 low while on", wr_ok, 0);
    @(negedge clk) tmr_en = 0;
    chk("R8 low after off", wr_ok, 0);
    pulse_rtc(1);
    chk("R8 one tick", wr_ok, 0);
    pulse_rtc(1);
    chk("R8 two ticks", wr_ok, 1);

    // R9: settings ignored before wr_ok rises
    arm(3'b011, 16'd1);
    pulse_rtc(3);
    @(negedge clk) tmr_en = 0;
    reload = 16'd7; clk_sel = 3'b000;
    @(negedge clk);
    chk("R9 wr_ok low", wr_ok, 0);
    tmr_en = 1;
    @(negedge clk);
    pulse_rtc(3);
    chk("R9 early", wake_flag, 0);
    pulse_rtc(1);
    chk("R9 old reload kept", wake_flag, 1);

    // R10 disabled counting and restart
    arm(3'b011, 16'd3);
    pulse_rtc(5);
    @(negedge clk) tmr_en = 0;
    pulse_rtc(40);
    chk("R10 no flag off", wake_flag, 0);
    @(negedge clk) tmr_en = 1;
    @(negedge clk);
    pulse_rtc(7);
    chk("R10 restart early", wake_flag, 0);
    pulse_rtc(1);
    chk("R10 restart due", wake_flag, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule